// File: doc/BRIEF.md
# Interrupt Aggregator with Hidden Non-Maskable Sources

This block gathers interrupt requests from peripherals into a pending register and drives one interrupt line to the CPU. A peripheral raises a request by pulsing bits of a set vector and withdraws it by pulsing bits of a clear vector. Each bit stays pending until it is cleared explicitly.

A host bus sees two 8-bit registers. The mask register can be read and written. The low byte of the pending register can only be read. The pending register is wider than 8 bits (parameter `NUM_SRC`, default 12, at least 9). Bits from 8 upward are non-maskable sources. They drive the CPU line whatever the mask holds, and the bus never sees them.

The CPU line is registered. It reflects the effect of a set, a clear or a mask write on the clock edge that stores that change.

Top module: `irqAgg`

## Requirements
- R1: After reset, the mask register is 0, every pending bit is 0, and `cpuIrq` is 0.
- R2: A cycle with `busWrEn` high stores `busWrData` in the mask register. A 1 in a mask bit enables that source. With `busRdSel` = 0, `busRdData` returns the mask register combinationally.
- R3: Each 1 in `setVec` sets the matching pending bit on the next clock edge. Pending bits whose `setVec` bit is 0 are not changed by that vector.
- R4: Each 1 in `clrVec` clears the matching pending bit on the next clock edge. Pending bits whose `clrVec` bit is 0 are not changed by that vector.
- R5: If the same bit is high in both `setVec` and `clrVec` in one cycle, the bit ends up set.
- R6: With `busRdSel` = 1, `busRdData` returns pending bits 7:0. Pending bits 8 and above never appear on the bus.
- R7: `cpuIrq` is a register that holds the OR of two terms: the AND of pending[7:0] with the mask, and any set bit in pending[NUM_SRC-1:8]. It takes the value caused by a strobe or mask write on the edge that stores it.
- R8: Pending bits 8 and above raise `cpuIrq` even when the mask register is all zeros. No mask write can suppress them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setVec | input | NUM_SRC | Per-bit request set strobes |
| clrVec | input | NUM_SRC | Per-bit request clear strobes |
| busWrEn | input | 1 | Mask register write strobe |
| busWrData | input | 8 | Mask register write data |
| busRdSel | input | 1 | Read select: 0 = mask, 1 = pending low byte |
| busRdData | output | 8 | Combinational read data |
| cpuIrq | output | 1 | Registered CPU interrupt request |

## Verification
The bench sweeps all 256 mask values against each of the twelve pending bits, one bit at a time. Any mix-up between maskable and non-maskable bits shows up there: the CPU line rises when it should stay low, or a hidden bit appears on the bus. A directed check sets and clears the same bit in one cycle. A design where the clear wins would leave that bit at zero and the CPU line low. A long pseudo-random run mixes overlapping set vectors, clear vectors and mask writes. It catches a CPU line that lags a cycle behind the stored state, and a strobe that disturbs bits it did not name.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam int unsigned LowW = 8;

  typedef struct packed {
    logic            wrMask;
    logic [LowW-1:0] maskData;
    logic            rdPending;
  } busCtrlT;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
(
  input  logic            busWrEn,
  input  logic [LowW-1:0] busWrData,
  input  logic            busRdSel,
  output busCtrlT         ctrl
);
  always_comb begin
    ctrl.wrMask    = busWrEn;
    ctrl.maskData  = busWrData;
    ctrl.rdPending = busRdSel;
  end
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int unsigned NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  busCtrlT            ctrl,
  input  logic [NUM_SRC-1:0] setVec,
  input  logic [NUM_SRC-1:0] clrVec,
  output logic [LowW-1:0]    rdData,
  output logic               cpuIrq
);
  localparam int unsigned HighW = NUM_SRC - LowW;

  logic [NUM_SRC-1:0] pending, pendNext;
  logic [LowW-1:0]    mask, maskNext;
  logic [NUM_SRC-1:0] activeNext, activeNow;

  // Set is applied after clear, so a simultaneous set wins.
  always_comb begin
    pendNext = (pending & ~clrVec) | setVec;
    maskNext = ctrl.wrMask ? ctrl.maskData : mask;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    if (i < LowW) begin : gMaskable
      assign activeNext[i] = pendNext[i] & maskNext[i];
      assign activeNow[i]  = pending[i] & mask[i];
    end else begin : gHidden
      assign activeNext[i] = pendNext[i];
      assign activeNow[i]  = pending[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      mask    <= '0;
      cpuIrq  <= 1'b0;
    end else begin
      pending <= pendNext;
      mask    <= maskNext;
      cpuIrq  <= |activeNext;
    end
  end

  assign rdData = ctrl.rdPending ? pending[LowW-1:0] : mask;

  // R3
  set_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((pending & $past(setVec)) == $past(setVec)));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec != '0) |=> ((pending & ($past(clrVec) & ~$past(setVec))) == '0));

  // R3 R4: untouched bits hold
  untouched_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((pending ^ $past(pending)) & ~($past(setVec) | $past(clrVec))) == '0));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrMask |=> $stable(mask));

  // R7
  irq_matches_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (|activeNow));

  // R8
  hidden_unmaskable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pending[NUM_SRC-1:LowW]) |-> cpuIrq);

  // R6
  hidden_invisible_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rdPending |-> (rdData == pending[LowW-1:0]));

  initial begin
    if (HighW < 1) $display("irqAggDatapath: NUM_SRC must be at least 9");
  end
endmodule

// File: rtl/irqAgg.sv
module irqAgg
  import irqAggPkg::*;
#(
  parameter int unsigned NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] setVec,
  input  logic [NUM_SRC-1:0] clrVec,
  input  logic               busWrEn,
  input  logic [7:0]         busWrData,
  input  logic               busRdSel,
  output logic [7:0]         busRdData,
  output logic               cpuIrq
);
  busCtrlT ctrl;

  irqAggCtrl uCtrl (
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdSel (busRdSel),
    .ctrl     (ctrl)
  );

  irqAggDatapath #(.NUM_SRC(NUM_SRC)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .setVec(setVec),
    .clrVec(clrVec),
    .rdData(busRdData),
    .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/irqAgg_test.sv
module irqAgg_test;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] setVec = '0;
  logic [N-1:0] clrVec = '0;
  logic         busWrEn = 1'b0;
  logic [7:0]   busWrData = '0;
  logic         busRdSel = 1'b0;
  logic [7:0]   busRdData;
  logic         cpuIrq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  irqAgg #(.NUM_SRC(N)) uut (
    .clk(clk), .rstN(rstN), .setVec(setVec), .clrVec(clrVec),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdSel(busRdSel),
    .busRdData(busRdData), .cpuIrq(cpuIrq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    setVec  = '0;
    clrVec  = '0;
    busWrEn = 1'b0;
  endtask

  task automatic readBoth(input logic [7:0] expMask, input logic [7:0] expPend, input string req);
    busRdSel = 1'b0; #1;
    chk({req, " mask read"}, {24'b0, busRdData}, {24'b0, expMask});
    busRdSel = 1'b1; #1;
    chk({req, " pending read"}, {24'b0, busRdData}, {24'b0, expPend});
  endtask

  initial begin
    logic [N-1:0] mPend;
    logic [7:0]   mMask;
    logic [31:0]  lfsr;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1;
    // R1
    readBoth(8'h00, 8'h00, "R1");
    chk("R1 cpuIrq", {31'b0, cpuIrq}, 0);

    // Exhaustive sweep: every mask value against every single source bit
    for (int m = 0; m < 256; m++) begin
      busWrEn = 1'b1; busWrData = m[7:0];
      step();
      readBoth(m[7:0], 8'h00, "R2");
      chk("R7 idle cpuIrq", {31'b0, cpuIrq}, 0);
      for (int i = 0; i < N; i++) begin
        setVec = N'(1) << i;
        step();
        // R6: hidden bits never visible
        busRdSel = 1'b1; #1;
        chk("R3 R6 single set", {24'b0, busRdData}, (i < 8) ? (32'd1 << i) : 32'd0);
        // R7 R8
        chk("R7 R8 cpuIrq", {31'b0, cpuIrq}, ((i >= 8) || m[i]) ? 1 : 0);
        clrVec = N'(1) << i;
        step();
        chk("R4 single clear", {24'b0, busRdData}, 0);
        chk("R4 cpuIrq drop", {31'b0, cpuIrq}, 0);
      end
    end

    // R5: set and clear of the same bit in one cycle
    busWrEn = 1'b1; busWrData = 8'h08;
    step();
    setVec = N'(12'h008); clrVec = N'(12'h008);
    step();
    busRdSel = 1'b1; #1;
    chk("R5 set wins", {24'b0, busRdData}, 32'h08);
    chk("R5 cpuIrq", {31'b0, cpuIrq}, 1);
    setVec = N'(12'h400); clrVec = N'(12'h408);
    step();
    busRdSel = 1'b1; #1;
    chk("R5 hidden set wins, low clear", {24'b0, busRdData}, 0);
    chk("R5 R8 hidden keeps cpuIrq", {31'b0, cpuIrq}, 1);
    // R8: mask of zero cannot suppress hidden source
    busWrEn = 1'b1; busWrData = 8'h00;
    step();
    chk("R8 zero mask", {31'b0, cpuIrq}, 1);
    clrVec = '1;
    step();
    chk("R4 clear all", {31'b0, cpuIrq}, 0);

    // Pseudo-random mix with an arithmetic model
    mPend = '0; mMask = 8'h00; lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      setVec = lfsr[11:0] & {lfsr[27], lfsr[26], lfsr[25], 9'h1FF};
      clrVec = lfsr[23:12] | {4'b0, lfsr[31:24] & 8'h00};
      busWrEn = lfsr[28] & lfsr[29];
      busWrData = lfsr[31:24] ^ lfsr[7:0];
      mPend = (mPend & ~clrVec) | setVec;
      if (busWrEn) mMask = busWrData;
      step();
      readBoth(mMask, mPend[7:0], "R2 R3 R4 R6 random");
      chk("R7 random cpuIrq", {31'b0, cpuIrq},
          ((|(mPend[7:0] & mMask)) || (|mPend[N-1:8])) ? 1 : 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule